// File: doc/BRIEF.md
# Synthesizer Configuration Register Interface

This block holds the setting word of a clock synthesizer: a 7-bit feedback divider value, a 2-bit post-divider code and a 3-bit test-select code. Software or board logic can write the setting through either of two ports. One is a three-wire serial port made of a data line, a shift clock and a load strobe. It fills a 12-bit shift register. The other is a parallel port that presents the divider value and the post-divider code directly, with its own load strobe.

Both ports feed the same configuration latches. The two strobes have opposite polarity. The serial strobe opens the latches while it is high, and the parallel strobe opens the divider and post-divider latches while it is low. Whatever the latch holds when its strobe closes is kept. When both ports try to load at once, the parallel port wins for the divider and the post-divider. The test-select code can only be written from the serial side.

All port inputs are sampled by the system clock `clk`. A serial shift happens on the first `clk` edge that sees the shift clock high after it was low.

Top module: `synth_cfg_regs`

## Requirements
- R1: Each low-to-high transition of `serClk` shifts the 12-bit shift register one place toward bit 11 and puts `serData` into bit 0. The first of twelve bits sent therefore ends up in bit 11.
- R2: In the shift register, bits 11..5 map to the divider value (bit 11 is its MSB), bit 4 maps to N[1], bit 3 maps to N[0], and bits 2..0 map to the test code (bit 2 is its MSB).
- R3: While `serLoad` is high and `parStrobe` is high, `cfgM`, `cfgN` and `cfgT` follow the shift-register fields. Serial data shifted while the strobe is high therefore shows on the outputs.
- R4: While `parStrobe` is low, `cfgM` and `cfgN` follow `parM` and `parN`. After `parStrobe` rises, later changes on `parM` and `parN` have no effect.
- R5: While `parStrobe` is low, a serial load does not change `cfgM` or `cfgN`. They keep following the parallel inputs.
- R6: `cfgT` changes only through a serial load, and the parallel strobe does not gate it. A parallel load leaves `cfgT` unchanged.
- R7: While both strobes are inactive (`serLoad` low, `parStrobe` high), all outputs hold their values, even when new serial data is shifted in.
- R8: After reset, `cfgM`, `cfgN` and `cfgT` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples every input |
| rst_n | input | 1 | Asynchronous active-low reset |
| serClk | input | 1 | Serial shift clock; its rising edge shifts |
| serData | input | 1 | Serial data bit |
| serLoad | input | 1 | Serial load strobe, latches open while high |
| parStrobe | input | 1 | Parallel load strobe, latches open while low |
| parM | input | 7 | Parallel divider value |
| parN | input | 2 | Parallel post-divider code |
| cfgM | output | 7 | Latched divider value |
| cfgN | output | 2 | Latched post-divider code |
| cfgT | output | 3 | Latched test-select code |

## Verification
The two load paths can act in the same cycle: a serial load strobe can be high while the parallel strobe is low. The bench provokes this by holding the parallel strobe low with known inputs and then running a full serial shift and load underneath it. It judges the result at the outputs. The divider and post-divider must still show the parallel values, and the test code must take the serial field. A second case shifts serial data while the serial strobe stays open, with no parallel activity, to confirm that the outputs pass the shift register through.

// File: rtl/synth_cfg_pkg.sv
package synth_cfg_pkg;
  localparam int M_W = 7;
  localparam int N_W = 2;
  localparam int T_W = 3;
  localparam int SHIFT_W = M_W + N_W + T_W;
  localparam int T_LSB = 0;
  localparam int N_LSB = T_LSB + T_W;
  localparam int M_LSB = N_LSB + N_W;

  typedef struct packed {
    logic shiftEn;
    logic mnFromPar;
    logic mnFromSer;
    logic tFromSer;
  } cfg_strobe_t;
endpackage

// File: rtl/synth_cfg_ctrl.sv
module synth_cfg_ctrl
  import synth_cfg_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        serClk,
  input  logic        serLoad,
  input  logic        parStrobe,
  output cfg_strobe_t strb
);
  logic serClkQ;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) serClkQ <= 1'b0;
    else        serClkQ <= serClk;
  end

  always_comb begin
    strb.shiftEn   = serClk & ~serClkQ;
    strb.mnFromPar = ~parStrobe;
    strb.mnFromSer = serLoad & parStrobe;
    strb.tFromSer  = serLoad;
  end

  // R5: the two divider sources are never enabled together
  a_r5_one_source: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({strb.mnFromPar, strb.mnFromSer}));
endmodule

// File: rtl/synth_cfg_dp.sv
module synth_cfg_dp
  import synth_cfg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  cfg_strobe_t      strb,
  input  logic             serData,
  input  logic [M_W-1:0]   parM,
  input  logic [N_W-1:0]   parN,
  output logic [M_W-1:0]   cfgM,
  output logic [N_W-1:0]   cfgN,
  output logic [T_W-1:0]   cfgT
);
  logic [SHIFT_W-1:0] shiftReg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            shiftReg <= '0;
    else if (strb.shiftEn) shiftReg <= {shiftReg[SHIFT_W-2:0], serData};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfgM <= '0;
      cfgN <= '0;
    end else if (strb.mnFromPar) begin
      cfgM <= parM;
      cfgN <= parN;
    end else if (strb.mnFromSer) begin
      cfgM <= shiftReg[M_LSB +: M_W];
      cfgN <= shiftReg[N_LSB +: N_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cfgT <= '0;
    else if (strb.tFromSer) cfgT <= shiftReg[T_LSB +: T_W];
  end

  // R1: a shift puts the sampled data bit at the low end
  a_r1_shift_in: assert property (@(posedge clk) disable iff (!rst_n)
    strb.shiftEn |=> shiftReg[0] == $past(serData));
  // R1: without a shift strobe the register holds
  a_r1_shift_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !strb.shiftEn |=> $stable(shiftReg));
endmodule

// File: rtl/synth_cfg_regs.sv
module synth_cfg_regs
  import synth_cfg_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           serClk,
  input  logic           serData,
  input  logic           serLoad,
  input  logic           parStrobe,
  input  logic [M_W-1:0] parM,
  input  logic [N_W-1:0] parN,
  output logic [M_W-1:0] cfgM,
  output logic [N_W-1:0] cfgN,
  output logic [T_W-1:0] cfgT
);
  cfg_strobe_t strb;

  synth_cfg_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .serClk(serClk), .serLoad(serLoad),
    .parStrobe(parStrobe), .strb(strb)
  );

  synth_cfg_dp u_dp (
    .clk(clk), .rst_n(rst_n), .strb(strb), .serData(serData),
    .parM(parM), .parN(parN), .cfgM(cfgM), .cfgN(cfgN), .cfgT(cfgT)
  );

  // R4: open parallel latch passes the inputs
  a_r4_par_follow: assert property (@(posedge clk) disable iff (!rst_n)
    !parStrobe |=> (cfgM == $past(parM)) && (cfgN == $past(parN)));
  // R5: parallel wins over a concurrent serial load
  a_r5_par_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (!parStrobe && serLoad) |=> cfgN == $past(parN));
  // R6: test code moves only under the serial strobe
  a_r6_t_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !serLoad |=> $stable(cfgT));
  // R7: both strobes closed keeps the divider fields
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (parStrobe && !serLoad) |=> $stable(cfgM) && $stable(cfgN));
endmodule

// File: tb/synth_cfg_regs_tb.sv
module synth_cfg_regs_tb;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic serClk = 1'b0, serData = 1'b0, serLoad = 1'b0, parStrobe = 1'b1;
  logic [6:0] parM = 7'h7f;
  logic [1:0] parN = 2'h3;
  logic [6:0] cfgM;
  logic [1:0] cfgN;
  logic [2:0] cfgT;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    string      tag;
    logic [6:0] m;
    logic [1:0] n;
    logic [2:0] t;
  } exp_t;
  exp_t expQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  synth_cfg_regs u_dut (
    .clk(clk), .rst_n(rst_n), .serClk(serClk), .serData(serData),
    .serLoad(serLoad), .parStrobe(parStrobe), .parM(parM), .parN(parN),
    .cfgM(cfgM), .cfgN(cfgN), .cfgT(cfgT)
  );

  // monitor: compare queued expectations at the falling edge
  always @(negedge clk) begin
    if (expQ.size() > 0) begin
      exp_t e;
      e = expQ.pop_front();
      checks++;
      if (cfgM !== e.m || cfgN !== e.n || cfgT !== e.t) begin
        errors++;
        $display("FAIL %s: got M=%h N=%h T=%h expected M=%h N=%h T=%h",
                 e.tag, cfgM, cfgN, cfgT, e.m, e.n, e.t);
      end
    end
  end

  task automatic waitClk(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic expect3(string tag, logic [6:0] m, logic [1:0] n, logic [2:0] t);
    exp_t e;
    e.tag = tag; e.m = m; e.n = n; e.t = t;
    expQ.push_back(e);
    waitClk(1);
  endtask

  // first bit sent lands in bit 11
  task automatic shiftWord(logic [11:0] w);
    for (int i = 11; i >= 0; i--) begin
      serData = w[i];
      serClk  = 1'b0;
      waitClk(2);
      serClk  = 1'b1;
      waitClk(2);
    end
    serClk = 1'b0;
    waitClk(2);
  endtask

  task automatic serialLoad();
    serLoad = 1'b1;
    waitClk(3);
    serLoad = 1'b0;
    waitClk(3);
  endtask

  task automatic parallelLoad(logic [6:0] m, logic [1:0] n);
    parM = m; parN = n;
    parStrobe = 1'b0;
    waitClk(3);
    parStrobe = 1'b1;
    waitClk(3);
  endtask

  function automatic logic [11:0] mk(logic [6:0] m, logic [1:0] n, logic [2:0] t);
    return {m, n, t};
  endfunction

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    waitClk(3);
    expect3("R8 reset", 7'h00, 2'h0, 3'h0);
    rst_n = 1'b1;
    waitClk(2);
    expect3("R8 after release", 7'h00, 2'h0, 3'h0);

    // R1 R2 R3: serial write of a distinct pattern
    shiftWord(mk(7'h55, 2'h2, 3'h5));
    expect3("R7 shift without load", 7'h00, 2'h0, 3'h0);
    serialLoad();
    expect3("R1 R2 R3 serial load", 7'h55, 2'h2, 3'h5);

    // R7: new shift data with both strobes closed
    shiftWord(mk(7'h2a, 2'h1, 3'h2));
    expect3("R7 hold", 7'h55, 2'h2, 3'h5);

    // R2: field split with N[1]=0,N[0]=1 vs N[1]=1,N[0]=0 and MSB first
    serialLoad();
    expect3("R2 field map", 7'h2a, 2'h1, 3'h2);
    shiftWord(12'h801);
    serialLoad();
    expect3("R1 first bit to MSB", 7'h40, 2'h0, 3'h1);

    // R4 R6: parallel load keeps T
    parallelLoad(7'h1a, 2'h3);
    expect3("R4 R6 parallel load", 7'h1a, 2'h3, 3'h1);
    parM = 7'h00; parN = 2'h0;
    waitClk(3);
    expect3("R4 capture after rise", 7'h1a, 2'h3, 3'h1);

    // R4: transparency while strobe low
    parM = 7'h7f; parN = 2'h2;
    parStrobe = 1'b0;
    waitClk(3);
    expect3("R4 transparent a", 7'h7f, 2'h2, 3'h1);
    parM = 7'h00; parN = 2'h1;
    waitClk(3);
    expect3("R4 transparent b", 7'h00, 2'h1, 3'h1);

    // R5 R6: serial load while parallel strobe held low
    shiftWord(mk(7'h33, 2'h2, 3'h6));
    serialLoad();
    expect3("R5 parallel priority", 7'h00, 2'h1, 3'h6);
    parStrobe = 1'b1;
    waitClk(3);
    expect3("R5 after parallel close", 7'h00, 2'h1, 3'h6);

    // R3: serial latch transparent while strobe high
    serLoad = 1'b1;
    waitClk(3);
    expect3("R3 open shows shift reg", 7'h33, 2'h2, 3'h6);
    shiftWord(mk(7'h7f, 2'h3, 3'h7));
    expect3("R3 follows during shift", 7'h7f, 2'h3, 3'h7);
    serLoad = 1'b0;
    waitClk(3);
    shiftWord(mk(7'h00, 2'h0, 3'h0));
    expect3("R3 retained after fall", 7'h7f, 2'h3, 3'h7);

    // R6: parallel at boundary values, T untouched
    parallelLoad(7'h00, 2'h0);
    expect3("R6 parallel zero keeps T", 7'h00, 2'h0, 3'h7);

    waitClk(3);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule